// File: doc/BRIEF.md
# Effective address generator

This block forms the memory operand address of a 64-bit processor from instruction fields that an earlier stage has already pulled apart. It takes the operand-form byte (mode in bits 7:6, register/memory selector in bits 2:0), an optional scaled-index byte (scale in bits 7:6, index in bits 5:3, base in bits 2:0) and two register-extension bits, one for the base and one for the index. It also takes the displacement, a 64-bit/compatibility mode flag, an address-size override flag, the address of the next instruction and a read view of the sixteen general registers.

On a valid strobe it selects the base and index registers and scales the index by 1, 2, 4 or 8. It adds the sign-extended displacement, or in 64-bit mode the next-instruction address for the relative form. It then narrows the result to 32 bits where the mode or the override calls for that. The result and three flags are registered and appear one cycle later: relative-to-next-instruction, no base register, and no index register. The register-direct form (mode 11) is not a memory operand and is not handled.

Top module: `addr_calc`

## Requirements
- R1: In 64-bit mode, mode 00 with selector 101 yields next_ip_i plus the 32-bit displacement sign-extended to 64 bits, with ip_rel_o=1, no_base_o=0 and no_index_o=1.
- R2: The relative form is picked from the 3-bit selector alone, so ext_base_i=1 does not change it. Register 13 with no offset is reached through mode 01, selector 101, ext_base_i=1 and an 8-bit displacement of zero, and yields the value of register 13.
- R3: In compatibility mode, mode 00 with selector 101 yields the 32-bit displacement zero-extended, with ip_rel_o=0 and no_base_o=1.
- R4: With addr32_i=1 in 64-bit mode, the sum is cut to its low 32 bits and zero-extended. The relative form stays active under the override.
- R5: When a scaled-index byte is present (selector 100) with mode 00 and base field 101, no base register is used and the 32-bit displacement is added, with no_base_o=1. This holds in both modes.
- R6: An index field of 100 with ext_index_i=0 means no index (no_index_o=1, zero index term). With ext_index_i=1 the same field selects register 12 as the index.
- R7: Scale field values 00, 01, 10 and 11 multiply the index register by 1, 2, 4 and 8.
- R8: Mode 01 adds disp_i[7:0] sign-extended to 64 bits and ignores disp_i[31:8]. Mode 10 adds disp_i sign-extended to 64 bits. The register number is {extension bit, 3-bit field}.
- R9: In compatibility mode both extension bits are ignored, only registers 0 to 7 are addressed, and the address wraps modulo 2^32 with bits 63:32 zero.
- R10: Outputs change only on a clock edge where valid_i=1, with valid_o=1 in the following cycle, and hold while valid_i=0. Reset clears all outputs to zero.
- R11: Without a scaled-index byte (selector other than 100), no_index_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Fields are valid this cycle |
| form_i | input | 8 | Operand-form byte: mode [7:6], selector [2:0] |
| scix_i | input | 8 | Scaled-index byte: scale [7:6], index [5:3], base [2:0] |
| ext_base_i | input | 1 | Base/selector register extension bit |
| ext_index_i | input | 1 | Index register extension bit |
| disp_i | input | 32 | Displacement; low byte used for mode 01 |
| mode64_i | input | 1 | 1 = 64-bit mode, 0 = compatibility mode |
| addr32_i | input | 1 | Address-size override active |
| next_ip_i | input | 64 | Address of the next instruction |
| gpr_i | input | 16x64 | General register values, entry n is register n |
| ea_o | output | 64 | Registered effective address |
| ip_rel_o | output | 1 | Address is relative to the next instruction |
| no_base_o | output | 1 | No base register took part |
| no_index_o | output | 1 | No index register took part |
| valid_o | output | 1 | Outputs updated from the previous cycle's fields |

## Verification
The bench goes after the places where the selector byte is easy to over-decode. A design that folds ext_base_i into the relative-form check would return register 13 instead of the instruction-relative sum. A design that treats index field 100 as "none" without looking at ext_index_i would drop register 12 from the address. Override cases check that the relative form survives addr32_i and that only the low word remains; a design that switched the relative form off would return the bare displacement. Compatibility cases set both extension bits and pick register values whose sum carries past bit 31. Any leak of the extension bits or of the carry shows up directly in ea_o.

// File: rtl/addr_calc_pkg.sv
package addr_calc_pkg;

   localparam int REG_ID_W = 4;

   typedef enum logic [1:0] {
      DISP_NONE = 2'd0,
      DISP_BYTE = 2'd1,
      DISP_WORD = 2'd2
   } disp_kind_e;

   typedef struct packed {
      logic                ip_rel;
      logic                base_en;
      logic [REG_ID_W-1:0] base_id;
      logic                idx_en;
      logic [REG_ID_W-1:0] idx_id;
      logic [1:0]          scale;
      disp_kind_e          disp_kind;
   } ea_sel_t;

endpackage

// File: rtl/addr_calc_decode.sv
module addr_calc_decode
   import addr_calc_pkg::*;
(
   input  logic [7:0] form_i,
   input  logic [7:0] scix_i,
   input  logic       ext_base_i,
   input  logic       ext_index_i,
   input  logic       mode64_i,
   output ea_sel_t    sel_o
);

   localparam logic [2:0] SEL_SCIX   = 3'b100;
   localparam logic [2:0] SEL_NOREG  = 3'b101;
   localparam logic [REG_ID_W-1:0] ID_NO_INDEX = 4'b0100;

   logic [1:0] md;
   logic [2:0] sel;
   logic       eb;
   logic       ex;
   logic       unused_reg;

   assign md = form_i[7:6];
   assign sel = form_i[2:0];
   assign eb = ext_base_i & mode64_i;
   assign ex = ext_index_i & mode64_i;
   assign unused_reg = ^form_i[5:3];

   always_comb begin
      sel_o = '0;
      if (sel == SEL_SCIX) begin
         sel_o.base_id = {eb, scix_i[2:0]};
         sel_o.base_en = !(md == 2'b00 && scix_i[2:0] == SEL_NOREG);
         sel_o.idx_id  = {ex, scix_i[5:3]};
         sel_o.idx_en  = ({ex, scix_i[5:3]} != ID_NO_INDEX);
         sel_o.scale   = scix_i[7:6];
      end else begin
         sel_o.base_id = {eb, sel};
         sel_o.base_en = !(md == 2'b00 && sel == SEL_NOREG);
         sel_o.ip_rel  = mode64_i && md == 2'b00 && sel == SEL_NOREG;
      end
      case (md)
         2'b01:   sel_o.disp_kind = DISP_BYTE;
         2'b10:   sel_o.disp_kind = DISP_WORD;
         default: sel_o.disp_kind = sel_o.base_en ? DISP_NONE : DISP_WORD;
      endcase
   end

endmodule

// File: rtl/addr_calc_scale.sv
module addr_calc_scale #(
   parameter int XLEN        = 64,
   parameter int SCALE_STEPS = 4,
   localparam int SCALE_W    = $clog2(SCALE_STEPS)
) (
   input  logic [XLEN-1:0]    idx_i,
   input  logic [SCALE_W-1:0] scale_i,
   output logic [XLEN-1:0]    scaled_o
);

   logic [SCALE_STEPS-1:0][XLEN-1:0] shifted;

   for (genvar k = 0; k < SCALE_STEPS; k++) begin : g_step
      assign shifted[k] = idx_i << k;
   end

   assign scaled_o = shifted[scale_i];

endmodule

// File: rtl/addr_calc_sum.sv
module addr_calc_sum
   import addr_calc_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter int DISP_W   = 32,
   parameter int NARROW_W = 32
) (
   input  ea_sel_t           sel_i,
   input  logic [XLEN-1:0]   base_val_i,
   input  logic [XLEN-1:0]   scaled_i,
   input  logic [DISP_W-1:0] disp_i,
   input  logic [XLEN-1:0]   next_ip_i,
   input  logic              narrow_i,
   output logic [XLEN-1:0]   ea_o
);

   logic [XLEN-1:0] disp_ext;
   logic [XLEN-1:0] base_term;
   logic [XLEN-1:0] raw;

   always_comb begin
      case (sel_i.disp_kind)
         DISP_BYTE: disp_ext = {{(XLEN-8){disp_i[7]}}, disp_i[7:0]};
         DISP_WORD: disp_ext = {{(XLEN-DISP_W){disp_i[DISP_W-1]}}, disp_i};
         default:   disp_ext = '0;
      endcase
      if (sel_i.ip_rel)       base_term = next_ip_i;
      else if (sel_i.base_en) base_term = base_val_i;
      else                    base_term = '0;
   end

   assign raw = base_term + scaled_i + disp_ext;

   if (XLEN > NARROW_W) begin : g_narrow
      assign ea_o = narrow_i ? {{(XLEN-NARROW_W){1'b0}}, raw[NARROW_W-1:0]} : raw;
   end else begin : g_flat
      logic unused_narrow;
      assign unused_narrow = narrow_i;
      assign ea_o = raw;
   end

endmodule

// File: rtl/addr_calc.sv
module addr_calc
   import addr_calc_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter int DISP_W   = 32,
   parameter int NUM_REGS = 16,
   parameter int NARROW_W = 32
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           valid_i,
   input  logic [7:0]                     form_i,
   input  logic [7:0]                     scix_i,
   input  logic                           ext_base_i,
   input  logic                           ext_index_i,
   input  logic [DISP_W-1:0]              disp_i,
   input  logic                           mode64_i,
   input  logic                           addr32_i,
   input  logic [XLEN-1:0]                next_ip_i,
   input  logic [NUM_REGS-1:0][XLEN-1:0]  gpr_i,
   output logic [XLEN-1:0]                ea_o,
   output logic                           ip_rel_o,
   output logic                           no_base_o,
   output logic                           no_index_o,
   output logic                           valid_o
);

   localparam int ID_W = $clog2(NUM_REGS);

   if (NUM_REGS != (1 << REG_ID_W)) begin : g_bad_regs
      $error("addr_calc: NUM_REGS must equal 2**REG_ID_W");
   end
   if (ID_W != REG_ID_W) begin : g_bad_id
      $error("addr_calc: register id width mismatch");
   end
   if (DISP_W < 8 || DISP_W > XLEN) begin : g_bad_disp
      $error("addr_calc: DISP_W out of range");
   end
   if (NARROW_W > XLEN) begin : g_bad_narrow
      $error("addr_calc: NARROW_W wider than XLEN");
   end

   ea_sel_t         sel;
   logic [XLEN-1:0] base_val;
   logic [XLEN-1:0] idx_val;
   logic [XLEN-1:0] scaled;
   logic [XLEN-1:0] ea_next;
   logic            narrow;

   addr_calc_decode u_decode (
      .form_i      (form_i),
      .scix_i      (scix_i),
      .ext_base_i  (ext_base_i),
      .ext_index_i (ext_index_i),
      .mode64_i    (mode64_i),
      .sel_o       (sel)
   );

   assign base_val = gpr_i[sel.base_id];
   assign idx_val  = sel.idx_en ? gpr_i[sel.idx_id] : '0;
   assign narrow   = !mode64_i || addr32_i;

   addr_calc_scale #(
      .XLEN        (XLEN),
      .SCALE_STEPS (4)
   ) u_scale (
      .idx_i    (idx_val),
      .scale_i  (sel.scale),
      .scaled_o (scaled)
   );

   addr_calc_sum #(
      .XLEN     (XLEN),
      .DISP_W   (DISP_W),
      .NARROW_W (NARROW_W)
   ) u_sum (
      .sel_i      (sel),
      .base_val_i (base_val),
      .scaled_i   (scaled),
      .disp_i     (disp_i),
      .next_ip_i  (next_ip_i),
      .narrow_i   (narrow),
      .ea_o       (ea_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ea_o       <= '0;
         ip_rel_o   <= 1'b0;
         no_base_o  <= 1'b0;
         no_index_o <= 1'b0;
         valid_o    <= 1'b0;
      end else begin
         valid_o <= valid_i;
         if (valid_i) begin
            ea_o       <= ea_next;
            ip_rel_o   <= sel.ip_rel;
            no_base_o  <= !sel.base_en && !sel.ip_rel;
            no_index_o <= !sel.idx_en;
         end
      end
   end

endmodule

// File: rtl/addr_calc_chk.sv
module addr_calc_chk #(
   parameter int XLEN     = 64,
   parameter int NARROW_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            valid_i,
   input logic [7:0]      form_i,
   input logic [7:0]      scix_i,
   input logic            mode64_i,
   input logic            addr32_i,
   input logic [XLEN-1:0] ea_o,
   input logic            ip_rel_o,
   input logic            no_base_o,
   input logic            no_index_o,
   input logic            valid_o
);

   AST_IPREL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && mode64_i && form_i[7:6] == 2'b00 && form_i[2:0] == 3'b101)
      |=> (ip_rel_o && !no_base_o && no_index_o)); // R1

   AST_COMPAT_NO_IPREL: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && !mode64_i) |=> !ip_rel_o); // R3

   AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && (!mode64_i || addr32_i)) |=> (ea_o[XLEN-1:NARROW_W] == '0)); // R4

   AST_SCIX_NO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && form_i[7:6] == 2'b00 && form_i[2:0] == 3'b100 && scix_i[2:0] == 3'b101)
      |=> (no_base_o && !ip_rel_o)); // R5

   AST_NO_SCIX_NO_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && form_i[2:0] != 3'b100) |=> no_index_o); // R11

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> ($stable(ea_o) && $stable(ip_rel_o) && $stable(no_base_o) && !valid_o)); // R10

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> valid_o); // R10

endmodule

bind addr_calc addr_calc_chk #(
   .XLEN     (XLEN),
   .NARROW_W (NARROW_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .valid_i    (valid_i),
   .form_i     (form_i),
   .scix_i     (scix_i),
   .mode64_i   (mode64_i),
   .addr32_i   (addr32_i),
   .ea_o       (ea_o),
   .ip_rel_o   (ip_rel_o),
   .no_base_o  (no_base_o),
   .no_index_o (no_index_o),
   .valid_o    (valid_o)
);

// File: tb/addr_calc_test.sv
`timescale 1ns/1ps
module addr_calc_test;

   function automatic logic [63:0] rv(int i);
      return {16'hC0DE, 8'(i), 8'h00, 32'hF000_0000 + 32'(i) * 32'h0100_0010};
   endfunction

   function automatic logic [31:0] rl(int i);
      logic [63:0] v;
      v = rv(i);
      return v[31:0];
   endfunction

   localparam logic [63:0] NIP = 64'h0000_1234_FFFF_FF00;

   typedef struct packed {
      logic [23:0] tag;
      logic [7:0]  frm;
      logic [7:0]  scx;
      logic        eb;
      logic        ex;
      logic [31:0] disp;
      logic        m64;
      logic        a32;
      logic [63:0] ea;
      logic        ipr;
      logic        nb;
      logic        ni;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VEC [NV] = '{
      '{"R1",  8'h05, 8'h00, 1'b0, 1'b0, 32'h0000_0100, 1'b1, 1'b0, NIP + 64'h100, 1'b1, 1'b0, 1'b1},
      '{"R1",  8'h05, 8'h00, 1'b0, 1'b0, 32'hFFFF_FF00, 1'b1, 1'b0, NIP - 64'h100, 1'b1, 1'b0, 1'b1},
      '{"R2",  8'h05, 8'h00, 1'b1, 1'b0, 32'h0000_0010, 1'b1, 1'b0, NIP + 64'h10,  1'b1, 1'b0, 1'b1},
      '{"R2",  8'h45, 8'h00, 1'b1, 1'b0, 32'h0000_0000, 1'b1, 1'b0, rv(13),        1'b0, 1'b0, 1'b1},
      '{"R3",  8'h05, 8'h00, 1'b0, 1'b0, 32'h8000_0004, 1'b0, 1'b0, 64'h8000_0004, 1'b0, 1'b1, 1'b1},
      '{"R4",  8'h05, 8'h00, 1'b0, 1'b0, 32'h0000_0010, 1'b1, 1'b1, 64'hFFFF_FF10, 1'b1, 1'b0, 1'b1},
      '{"R4",  8'h80, 8'h00, 1'b0, 1'b0, 32'h2000_0000, 1'b1, 1'b1, {32'h0, 32'(rl(0) + 32'h2000_0000)}, 1'b0, 1'b0, 1'b1},
      '{"R5",  8'h04, 8'h0D, 1'b0, 1'b0, 32'h0000_0040, 1'b1, 1'b0, rv(1) + 64'h40, 1'b0, 1'b1, 1'b0},
      '{"R5",  8'h04, 8'h0D, 1'b0, 1'b0, 32'h0000_0040, 1'b0, 1'b0, {32'h0, 32'(rl(1) + 32'h40)}, 1'b0, 1'b1, 1'b0},
      '{"R6",  8'h04, 8'h20, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b0, rv(0),          1'b0, 1'b0, 1'b1},
      '{"R6",  8'h04, 8'h20, 1'b0, 1'b1, 32'h0000_0000, 1'b1, 1'b0, rv(0) + rv(12), 1'b0, 1'b0, 1'b0},
      '{"R7",  8'h44, 8'h53, 1'b0, 1'b0, 32'h0000_00FC, 1'b1, 1'b0, rv(3) + rv(2) * 2 - 64'd4, 1'b0, 1'b0, 1'b0},
      '{"R7",  8'h04, 8'h93, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b0, rv(3) + rv(2) * 4, 1'b0, 1'b0, 1'b0},
      '{"R7",  8'h84, 8'hD9, 1'b1, 1'b1, 32'h0000_0100, 1'b1, 1'b0, rv(9) + rv(11) * 8 + 64'h100, 1'b0, 1'b0, 1'b0},
      '{"R8",  8'h46, 8'h00, 1'b0, 1'b0, 32'h1234_5680, 1'b1, 1'b0, rv(6) - 64'd128, 1'b0, 1'b0, 1'b1},
      '{"R8",  8'h82, 8'h00, 1'b1, 1'b0, 32'h8000_0000, 1'b1, 1'b0, rv(10) + 64'hFFFF_FFFF_8000_0000, 1'b0, 1'b0, 1'b1},
      '{"R9",  8'h87, 8'h00, 1'b1, 1'b0, 32'h1000_0000, 1'b0, 1'b0, {32'h0, 32'(rl(7) + 32'h1000_0000)}, 1'b0, 1'b0, 1'b1},
      '{"R9",  8'h04, 8'h24, 1'b1, 1'b1, 32'h0000_0000, 1'b0, 1'b0, {32'h0, rl(4)}, 1'b0, 1'b0, 1'b1},
      '{"R11", 8'h03, 8'h00, 1'b0, 1'b0, 32'h0000_0000, 1'b1, 1'b0, rv(3),          1'b0, 1'b0, 1'b1}
   };

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  valid_i = 1'b0;
   logic [7:0]            form_i = '0;
   logic [7:0]            scix_i = '0;
   logic                  ext_base_i = 1'b0;
   logic                  ext_index_i = 1'b0;
   logic [31:0]           disp_i = '0;
   logic                  mode64_i = 1'b0;
   logic                  addr32_i = 1'b0;
   logic [63:0]           next_ip_i = NIP;
   logic [15:0][63:0]     gpr_i;
   logic [63:0]           ea_o;
   logic                  ip_rel_o;
   logic                  no_base_o;
   logic                  no_index_o;
   logic                  valid_o;

   int n_run  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   addr_calc uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .valid_i     (valid_i),
      .form_i      (form_i),
      .scix_i      (scix_i),
      .ext_base_i  (ext_base_i),
      .ext_index_i (ext_index_i),
      .disp_i      (disp_i),
      .mode64_i    (mode64_i),
      .addr32_i    (addr32_i),
      .next_ip_i   (next_ip_i),
      .gpr_i       (gpr_i),
      .ea_o        (ea_o),
      .ip_rel_o    (ip_rel_o),
      .no_base_o   (no_base_o),
      .no_index_o  (no_index_o),
      .valid_o     (valid_o)
   );

   task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 16; i++) gpr_i[i] = rv(i);
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10", "reset ea", ea_o, 64'h0);
      check("R10", "reset flags", {60'h0, ip_rel_o, no_base_o, no_index_o, valid_o}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         form_i      = VEC[v].frm;
         scix_i      = VEC[v].scx;
         ext_base_i  = VEC[v].eb;
         ext_index_i = VEC[v].ex;
         disp_i      = VEC[v].disp;
         mode64_i    = VEC[v].m64;
         addr32_i    = VEC[v].a32;
         valid_i     = 1'b1;
         @(negedge clk);
         check(string'(VEC[v].tag), "ea", ea_o, VEC[v].ea);
         check(string'(VEC[v].tag), "flags ip/nb/ni",
               {61'h0, ip_rel_o, no_base_o, no_index_o},
               {61'h0, VEC[v].ipr, VEC[v].nb, VEC[v].ni});
         check("R10", "valid latency", {63'h0, valid_o}, 64'h1);
      end

      // R10: hold while valid_i is low, inputs changing
      valid_i  = 1'b0;
      form_i   = 8'h05;
      disp_i   = 32'h0BAD_0000;
      mode64_i = 1'b1;
      @(negedge clk);
      check("R10", "hold ea", ea_o, rv(3));
      check("R10", "idle valid", {63'h0, valid_o}, 64'h0);
      @(negedge clk);
      check("R10", "hold ip flag", {63'h0, ip_rel_o}, 64'h0);

      // R2: mode 00 selector 101 with extension bit under override
      valid_i    = 1'b1;
      ext_base_i = 1'b1;
      addr32_i   = 1'b1;
      disp_i     = 32'h0000_0200;
      @(negedge clk);
      check("R2", "ext bit ignored, override", ea_o, {32'h0, 32'(NIP[31:0] + 32'h200)});

      // R10: reset during operation clears outputs
      valid_i = 1'b0;
      rst_n   = 1'b0;
      @(negedge clk);
      check("R10", "mid reset ea", ea_o, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      finish_run();
   end

endmodule